// File: doc/BRIEF.md
# Dual-Register Segment Animation Engine

This block produces a moving segment pattern for a segmented display. It keeps two byte-wide pattern registers. On every step pulse, each register rotates left, rotates right or holds, under its own control code. The two registers are then merged bit by bit, with either AND or OR. The merged byte overwrites one chosen byte of a wider segment word, and the rest of that word passes through unchanged.

A small state counter advances once per step. When the counter reaches a programmable top value, the next step returns it to zero, and both pattern registers take their programmed start values again. The animation therefore repeats every `top + 1` steps. While the block is disabled, the segment word passes through untouched. In that mode the pattern registers follow their start values and the counter stays at zero, so enabling the block always begins a clean sequence.

Top module: `seg_anim_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, `anim_state` becomes 0 at that edge.
- R2: While `anim_en` is 0, `seg_out` equals `seg_in`, and `anim_state` is 0 after the next clock edge.
- R3: Shift code 1 rotates a pattern register left by one bit per step: bit 7 moves to bit 0.
- R4: Shift code 2 rotates a pattern register right by one bit per step: bit 0 moves to bit 7.
- R5: Shift codes 0 and 3 leave a pattern register unchanged on a step.
- R6: With `merge_or` = 0 the animated byte is the AND of the two registers. With `merge_or` = 1 it is their OR.
- R7: With `loc_sel` = 0 the animated byte replaces `seg_in[7:0]` and `seg_in[15:8]` passes through. With `loc_sel` = 1 it replaces `seg_in[15:8]` and `seg_in[7:0]` passes through.
- R8: While enabled, each step raises `anim_state` by 1 when it is below `state_top`. A step taken at `anim_state` equal to `state_top` sets it to 0. With `state_top` = 0 it stays at 0.
- R9: A step that returns `anim_state` to 0 reloads both registers with `start_a` and `start_b` instead of rotating them.
- R10: A clock edge without `step` changes neither `anim_state` nor `seg_out`.
- R11: If `state_top` is lowered below the current state, the next step sets `anim_state` to 0 and reloads both registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| anim_en | input | 1 | Animation enable |
| step | input | 1 | One-cycle animation step pulse |
| start_a | input | 8 | Start value of pattern register A |
| start_b | input | 8 | Start value of pattern register B |
| shift_a | input | 2 | Shift code for A (0 hold, 1 left, 2 right, 3 hold) |
| shift_b | input | 2 | Shift code for B (same codes) |
| merge_or | input | 1 | 0: AND merge, 1: OR merge |
| state_top | input | 3 | Highest state before wrap |
| loc_sel | input | 1 | Byte of the segment word that is overwritten |
| seg_in | input | 16 | Incoming segment word |
| seg_out | output | 16 | Segment word with the animated byte applied |
| anim_state | output | 4 | Current animation state |

## Verification
The bench builds the block with its default parameters: byte-wide registers, two byte slots, a 4-bit state and a 3-bit top. These values put every top count from 0 to 7 within reach, including the degenerate top of 0. Both byte locations and every shift code, including the spare code 3, are applied in combination with both merge functions. Directed sequences cover rotation across several steps, reload on wrap, lowering the top mid-sequence, idle edges and disabling mid-run.

// File: rtl/seg_anim_pkg.sv
// Package seg_anim_pkg
// Shared shift-code type for the animation engine. Assumes a 2-bit code in
// which the spare value 3 is treated the same as hold.
package seg_anim_pkg;

    typedef enum logic [1:0] {
        SHIFT_HOLD  = 2'd0,
        SHIFT_LEFT  = 2'd1,
        SHIFT_RIGHT = 2'd2,
        SHIFT_SPARE = 2'd3
    } shift_code_e;

endpackage

// File: rtl/seg_anim_shreg.sv
// Module seg_anim_shreg
// One rotating pattern register. Follows its start value while disabled,
// reloads it on a wrapping step and otherwise rotates per the shift code.
// Assumes adv is a single-cycle pulse and wrap is valid in the same cycle.
module seg_anim_shreg
    import seg_anim_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             adv,
    input  logic             wrap,
    input  logic [WIDTH-1:0] start_val,
    input  logic [1:0]       shift_code,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] rotated;

    // Next value of the register for a non-wrapping step.
    always_comb begin
        unique case (shift_code_e'(shift_code))
            SHIFT_LEFT:  rotated = {q[WIDTH-2:0], q[WIDTH-1]};
            SHIFT_RIGHT: rotated = {q[0], q[WIDTH-1:1]};
            default:     rotated = q;
        endcase
    end

    // Register update: reset, track/reload start value, or rotate on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (!en || (adv && wrap)) begin
            q <= start_val;
        end else if (adv) begin
            q <= rotated;
        end
    end

endmodule

// File: rtl/seg_anim_state_ctr.sv
// Module seg_anim_state_ctr
// Animation state counter. Counts steps up to a programmable top and then
// returns to zero; a state already above the top also returns to zero.
// Assumes TOP_W <= STATE_W. Held at zero while disabled.
module seg_anim_state_ctr #(
    parameter int STATE_W = 4,
    parameter int TOP_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               adv,
    input  logic [TOP_W-1:0]   top,
    output logic [STATE_W-1:0] state,
    output logic               wrap
);

    localparam int PAD_W = STATE_W - TOP_W;

    logic [STATE_W-1:0] top_ext;

    // Widen the top count and flag the end of a sequence.
    always_comb begin
        top_ext = {{PAD_W{1'b0}}, top};
        wrap    = (state >= top_ext);
    end

    // State update: reset, clear while disabled, advance or wrap on step.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state <= '0;
        end else if (adv) begin
            if (wrap) begin
                state <= '0;
            end else begin
                state <= state + {{(STATE_W-1){1'b0}}, 1'b1};
            end
        end
    end

endmodule

// File: rtl/seg_anim_overlay.sv
// Module seg_anim_overlay
// Places one byte onto a selected slot of a segment word. Slots that are not
// selected, and every slot while disabled, pass the input unchanged.
// Assumes the word holds exactly 2**LOC_W slots of BYTE_W bits.
module seg_anim_overlay #(
    parameter int BYTE_W = 8,
    parameter int LOC_W  = 1,
    localparam int SLOTS = 1 << LOC_W,
    localparam int SEG_W = BYTE_W * SLOTS
) (
    input  logic              en,
    input  logic [LOC_W-1:0]  loc,
    input  logic [BYTE_W-1:0] pattern,
    input  logic [SEG_W-1:0]  seg_in,
    output logic [SEG_W-1:0]  seg_out
);

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        // Per-slot select between pass-through and the animated byte.
        always_comb begin
            if (en && (loc == LOC_W'(k))) begin
                seg_out[k*BYTE_W +: BYTE_W] = pattern;
            end else begin
                seg_out[k*BYTE_W +: BYTE_W] = seg_in[k*BYTE_W +: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/seg_anim_engine.sv
// Module seg_anim_engine (top)
// Two rotating pattern registers are merged with AND or OR. The merged byte
// overwrites a chosen byte of the segment word. A state counter sets the
// sequence length and reloads the registers at its wrap.
// Assumes step is a one-cycle pulse synchronous to clk.
module seg_anim_engine #(
    parameter int BYTE_W  = 8,
    parameter int LOC_W   = 1,
    parameter int STATE_W = 4,
    parameter int TOP_W   = 3,
    localparam int SEG_W  = BYTE_W << LOC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               anim_en,
    input  logic               step,
    input  logic [BYTE_W-1:0]  start_a,
    input  logic [BYTE_W-1:0]  start_b,
    input  logic [1:0]         shift_a,
    input  logic [1:0]         shift_b,
    input  logic               merge_or,
    input  logic [TOP_W-1:0]   state_top,
    input  logic [LOC_W-1:0]   loc_sel,
    input  logic [SEG_W-1:0]   seg_in,
    output logic [SEG_W-1:0]   seg_out,
    output logic [STATE_W-1:0] anim_state
);

    logic              seq_wrap;
    logic [BYTE_W-1:0] reg_a;
    logic [BYTE_W-1:0] reg_b;
    logic [BYTE_W-1:0] merged;

    seg_anim_state_ctr #(
        .STATE_W (STATE_W),
        .TOP_W   (TOP_W)
    ) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (anim_en),
        .adv   (step),
        .top   (state_top),
        .state (anim_state),
        .wrap  (seq_wrap)
    );

    seg_anim_shreg #(.WIDTH(BYTE_W)) u_reg_a (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (anim_en),
        .adv        (step),
        .wrap       (seq_wrap),
        .start_val  (start_a),
        .shift_code (shift_a),
        .q          (reg_a)
    );

    seg_anim_shreg #(.WIDTH(BYTE_W)) u_reg_b (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (anim_en),
        .adv        (step),
        .wrap       (seq_wrap),
        .start_val  (start_b),
        .shift_code (shift_b),
        .q          (reg_b)
    );

    // Bitwise merge of the two pattern registers.
    always_comb begin
        merged = merge_or ? (reg_a | reg_b) : (reg_a & reg_b);
    end

    seg_anim_overlay #(
        .BYTE_W (BYTE_W),
        .LOC_W  (LOC_W)
    ) u_overlay (
        .en      (anim_en),
        .loc     (loc_sel),
        .pattern (merged),
        .seg_in  (seg_in),
        .seg_out (seg_out)
    );

endmodule

// File: rtl/seg_anim_engine_chk.sv
// Module seg_anim_engine_chk
// Port-level temporal checks for seg_anim_engine, attached by bind below.
module seg_anim_engine_chk #(
    parameter int BYTE_W  = 8,
    parameter int LOC_W   = 1,
    parameter int STATE_W = 4,
    parameter int TOP_W   = 3,
    localparam int SEG_W  = BYTE_W << LOC_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               anim_en,
    input logic               step,
    input logic [TOP_W-1:0]   state_top,
    input logic [LOC_W-1:0]   loc_sel,
    input logic [SEG_W-1:0]   seg_in,
    input logic [SEG_W-1:0]   seg_out,
    input logic [STATE_W-1:0] anim_state
);

    localparam int PAD_W = STATE_W - TOP_W;

    AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> anim_state == '0); // R1

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !anim_en |=> anim_state == '0); // R2

    AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (anim_en && step && anim_state < {{PAD_W{1'b0}}, state_top})
        |=> anim_state == STATE_W'($past(anim_state) + 1'b1)); // R8

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (anim_en && step && anim_state >= {{PAD_W{1'b0}}, state_top})
        |=> anim_state == '0); // R11

    AST_NO_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (anim_en && !step) |=> $stable(anim_state)); // R10

    AST_LOW_SLOT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (anim_en && loc_sel == '0) |-> seg_out[SEG_W-1:BYTE_W] == seg_in[SEG_W-1:BYTE_W]); // R7

endmodule

bind seg_anim_engine seg_anim_engine_chk #(
    .BYTE_W  (BYTE_W),
    .LOC_W   (LOC_W),
    .STATE_W (STATE_W),
    .TOP_W   (TOP_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .anim_en    (anim_en),
    .step       (step),
    .state_top  (state_top),
    .loc_sel    (loc_sel),
    .seg_in     (seg_in),
    .seg_out    (seg_out),
    .anim_state (anim_state)
);

// File: tb/tb_seg_anim_engine.sv
`timescale 1ns/1ps
// Bench for seg_anim_engine: table of single-step vectors, then directed tests.
module tb_seg_anim_engine;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        anim_en;
    logic        step;
    logic [7:0]  start_a, start_b;
    logic [1:0]  shift_a, shift_b;
    logic        merge_or;
    logic [2:0]  state_top;
    logic [0:0]  loc_sel;
    logic [15:0] seg_in;
    logic [15:0] seg_out;
    logic [3:0]  anim_state;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    seg_anim_engine dut (
        .clk(clk), .rst_n(rst_n), .anim_en(anim_en), .step(step),
        .start_a(start_a), .start_b(start_b), .shift_a(shift_a), .shift_b(shift_b),
        .merge_or(merge_or), .state_top(state_top), .loc_sel(loc_sel),
        .seg_in(seg_in), .seg_out(seg_out), .anim_state(anim_state)
    );

    // Vector: start_a, start_b, shift_a, shift_b, merge_or, loc_sel, seg_in, seg_out after one step
    localparam int NV = 6;
    localparam logic [53:0] VEC [NV] = '{
        {8'h81, 8'hFF, 2'd1, 2'd0, 1'b0, 1'b0, 16'hABCD, 16'hAB03},
        {8'h81, 8'h0F, 2'd2, 2'd1, 1'b1, 1'b1, 16'h1234, 16'hDE34},
        {8'h5A, 8'h3C, 2'd3, 2'd2, 1'b0, 1'b0, 16'hFFFF, 16'hFF1A},
        {8'h01, 8'h80, 2'd2, 2'd1, 1'b1, 1'b0, 16'h0000, 16'h0081},
        {8'hF0, 8'hAA, 2'd0, 2'd0, 1'b1, 1'b1, 16'h00FF, 16'hFAFF},
        {8'hC3, 8'h00, 2'd1, 2'd3, 1'b1, 1'b1, 16'h5555, 16'h8755}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Advance one clock; inputs change and outputs are sampled at the falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_step();
        step = 1'b1;
        tick();
        step = 1'b0;
    endtask

    // Disable, apply start values, then enable so the sequence starts clean.
    task automatic restart();
        anim_en = 1'b0;
        tick();
        tick();
        anim_en = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; anim_en = 1'b0; step = 1'b0;
        start_a = 8'h00; start_b = 8'h00; shift_a = 2'd0; shift_b = 2'd0;
        merge_or = 1'b0; state_top = 3'd7; loc_sel = 1'b0; seg_in = 16'h1357;
        @(negedge clk);
        anim_en = 1'b1; step = 1'b1;
        tick();
        tick();
        // R1: reset holds the state at zero even with enable and step high
        chk("R1", 32'(anim_state), 32'd0);
        step = 1'b0; anim_en = 1'b0; rst_n = 1'b1;
        tick();
        // R2: disabled block passes the segment word
        chk("R2 pass", 32'(seg_out), 32'h1357);
        state_top = 3'd7;

        // Table walk: R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            {start_a, start_b, shift_a, shift_b, merge_or, loc_sel, seg_in} = VEC[i][53:16];
            restart();
            pulse_step();
            chk($sformatf("R3/R4/R5/R6/R7 vec %0d", i), 32'(seg_out), 32'(VEC[i][15:0]));
            chk($sformatf("R8 vec %0d state", i), 32'(anim_state), 32'd1);
        end

        // Multi-step rotation and wrap with reload: R3, R8, R9
        start_a = 8'h01; start_b = 8'hFF; shift_a = 2'd1; shift_b = 2'd0;
        merge_or = 1'b0; loc_sel = 1'b0; seg_in = 16'h0000; state_top = 3'd2;
        restart();
        pulse_step();
        chk("R3 step1", 32'(seg_out), 32'h0002);
        pulse_step();
        chk("R3 step2", 32'(seg_out), 32'h0004);
        chk("R8 at top", 32'(anim_state), 32'd2);
        pulse_step();
        chk("R8 wrap", 32'(anim_state), 32'd0);
        chk("R9 reload", 32'(seg_out), 32'h0001);

        // R4 rotate right across bit 0 on the high slot
        start_a = 8'h02; shift_a = 2'd2; loc_sel = 1'b1; seg_in = 16'h00AA; state_top = 3'd7;
        restart();
        pulse_step();
        pulse_step();
        chk("R4 two steps", 32'(seg_out), 32'h80AA);

        // R10: idle edges change nothing
        tick(); tick(); tick();
        chk("R10 seg", 32'(seg_out), 32'h80AA);
        chk("R10 state", 32'(anim_state), 32'd2);

        // R8: top of zero keeps state at zero and reloads each step
        start_a = 8'h01; shift_a = 2'd1; loc_sel = 1'b0; seg_in = 16'h0000; state_top = 3'd0;
        restart();
        pulse_step();
        chk("R8 top0 state", 32'(anim_state), 32'd0);
        chk("R9 top0 reload", 32'(seg_out), 32'h0001);

        // R11: lowering top below the current state wraps and reloads
        state_top = 3'd7;
        restart();
        for (int s = 0; s < 5; s++) pulse_step();
        chk("R11 before", 32'(anim_state), 32'd5);
        chk("R3 five steps", 32'(seg_out), 32'h0020);
        state_top = 3'd2;
        pulse_step();
        chk("R11 state", 32'(anim_state), 32'd0);
        chk("R11 reload", 32'(seg_out), 32'h0001);

        // R2: disabling mid-run passes through and clears state
        pulse_step();
        seg_in = 16'hBEEF;
        anim_en = 1'b0;
        #1;
        chk("R2 pass mid", 32'(seg_out), 32'hBEEF);
        tick();
        chk("R2 state", 32'(anim_state), 32'd0);

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule